// File: doc/BRIEF.md
# AXI Burst Beat Expander

This block takes one address-channel burst request in AXI style and turns it into a stream of single-beat requests. Each of these carries the full byte address of its beat. The upstream request supplies the start address, burst type, transfer size, length and protection bits under a valid/ready handshake. The block then presents one beat at a time on a downstream valid/ready interface. Each beat comes with a final-beat flag and an 8-bit index of the beat being shown.

The block tracks a single burst at a time. Once a request is taken, the upstream ready stays low until the final beat has been handed off. A neighbouring memory port or register decoder can therefore treat each beat as an independent access. It can use the index output to see where one beat ends and the next begins. The address width is a parameter, 32 bits by default.

Top module: `axi_beat_expander`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `beat_valid` is 0 and `beat_idx` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. From the next cycle onward, `beat_valid` is 1, `beat_idx` is 0 and `beat_addr` equals the captured start address. Changes to the request inputs after that edge have no effect.
- R3: A burst with length field L produces exactly L+1 beats. `beat_last` is 1 only on the final beat and is 0 whenever `beat_valid` is 0.
- R4: The block moves to the next beat only on an edge where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, address, index, flag and protection bits hold steady.
- R5: The burst type field selects the address sequence: 0 is FIXED, 1 is INCR, 2 is WRAP. For INCR, each beat after the first is the previous address rounded down to the beat size, plus the beat size. The beat size is 2^`req_size` bytes. The address wraps modulo 2^ADDR_W.
- R6: For FIXED, every beat repeats the start address.
- R7: For WRAP, addresses step by the beat size within an aligned window of 2^`req_size` × (L+1) bytes. On passing the window's top they return to its base. The legal lengths are 2, 4, 8 and 16 beats.
- R8: If the start address is not aligned to the beat size, the first beat carries it unchanged. Every later INCR beat is aligned to the beat size.
- R9: `req_ready` is high only while no burst is held, so it is never high together with `beat_valid`. It returns high in the cycle after the final beat is handed off.
- R10: `beat_idx` equals the zero-based number of the beat currently presented. It rises by one on each non-final handoff.
- R11: `beat_prot` repeats the captured protection bits on every beat of the burst.
- R12: The unused burst type value 3 produces the same address sequence as INCR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Upstream burst request valid |
| req_ready | output | 1 | Upstream ready, high only when idle |
| req_addr | input | ADDR_W | Start byte address of the burst |
| req_burst | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP, 3 treated as INCR |
| req_size | input | SIZE_W | Log2 of the beat size in bytes |
| req_len | input | LEN_W | Beat count minus one |
| req_prot | input | PROT_W | Protection bits carried to every beat |
| beat_valid | output | 1 | Downstream beat valid |
| beat_ready | input | 1 | Downstream beat ready |
| beat_addr | output | ADDR_W | Full byte address of the presented beat |
| beat_prot | output | PROT_W | Protection bits of the burst |
| beat_last | output | 1 | High on the final beat of the burst |
| beat_idx | output | LEN_W | Zero-based index of the presented beat |

## Verification
The first beat appears one cycle after the accepting edge. Each later beat, or the return of `req_ready`, appears one cycle after the handoff edge that caused it. The bench drives and samples on falling edges, half a cycle after the rising edge that updates the outputs. At each falling edge it compares the outputs with the beat it expects next. It advances that beat number only when it has driven `beat_ready` high for the coming edge. The expected addresses come from closed-form formulas rather than a step-by-step copy. The sweep covers every burst type, sizes 1 to 8 bytes, lengths of 1, 2, 4, 8 and 16 beats, aligned and unaligned starts, a start near the top of the address space, and a fixed pattern of downstream stalls.

// File: rtl/beat_exp_pkg.sv
package beat_exp_pkg;

    // Burst type encoding on req_burst
    typedef enum logic [1:0] {
        BURST_FIXED = 2'd0,
        BURST_INCR  = 2'd1,
        BURST_WRAP  = 2'd2,
        BURST_RSVD  = 2'd3
    } burst_e;

endpackage

// File: rtl/beat_exp_addr_step.sv
// Combinational next-beat address for the three burst kinds.
module beat_exp_addr_step
    import beat_exp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_e            burst,
    input  logic [SIZE_W-1:0] size,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] nxt_addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] incr_addr;
    logic [ADDR_W-1:0] beat_total;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] wrap_addr;

    always_comb begin
        step_bytes = ONE << size;
        low_mask   = step_bytes - ONE;
        aligned    = cur_addr & ~low_mask;
        incr_addr  = aligned + step_bytes;
        beat_total = ADDR_W'(len) + ONE;
        win_mask   = (beat_total << size) - ONE;
        wrap_addr  = (aligned & ~win_mask) | (incr_addr & win_mask);
        case (burst)
            BURST_FIXED: nxt_addr = cur_addr;
            BURST_WRAP:  nxt_addr = wrap_addr;
            default:     nxt_addr = incr_addr;
        endcase
    end

endmodule

// File: rtl/beat_exp_counter.sv
// Beat index and length holder; flags the final beat.
module beat_exp_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] load_len,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] len,
    output logic             at_end
);

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.idx = '0;
            cnt_d.len = load_len;
        end else if (step) begin
            cnt_d.idx = cnt_q.idx + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx    = cnt_q.idx;
    assign len    = cnt_q.len;
    assign at_end = (cnt_q.idx == cnt_q.len);

endmodule

// File: rtl/axi_beat_expander.sv
// Expands one burst request into a sequence of single-beat requests.
module axi_beat_expander
    import beat_exp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3,
    parameter int PROT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [PROT_W-1:0] req_prot,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [PROT_W-1:0] beat_prot,
    output logic              beat_last,
    output logic [LEN_W-1:0]  beat_idx
);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        burst_e            burst;
        logic [SIZE_W-1:0] size;
        logic [PROT_W-1:0] prot;
    } ctx_s;

    ctx_s ctx_d, ctx_q;

    logic              accept;
    logic              handoff;
    logic              final_beat;
    logic [LEN_W-1:0]  cur_idx;
    logic [LEN_W-1:0]  cur_len;
    logic [ADDR_W-1:0] step_addr;

    assign accept  = req_valid & ~ctx_q.busy;
    assign handoff = ctx_q.busy & beat_ready;

    beat_exp_counter #(
        .LEN_W (LEN_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (handoff & ~final_beat),
        .load_len (req_len),
        .idx      (cur_idx),
        .len      (cur_len),
        .at_end   (final_beat)
    );

    beat_exp_addr_step #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SIZE_W (SIZE_W)
    ) u_addr_step (
        .cur_addr (ctx_q.addr),
        .burst    (ctx_q.burst),
        .size     (ctx_q.size),
        .len      (cur_len),
        .nxt_addr (step_addr)
    );

    always_comb begin
        ctx_d = ctx_q;
        if (accept) begin
            ctx_d.busy  = 1'b1;
            ctx_d.addr  = req_addr;
            ctx_d.burst = burst_e'(req_burst);
            ctx_d.size  = req_size;
            ctx_d.prot  = req_prot;
        end else if (handoff) begin
            if (final_beat) ctx_d.busy = 1'b0;
            else            ctx_d.addr = step_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready  = ~ctx_q.busy;
    assign beat_valid = ctx_q.busy;
    assign beat_addr  = ctx_q.addr;
    assign beat_prot  = ctx_q.prot;
    assign beat_last  = ctx_q.busy & final_beat;
    assign beat_idx   = cur_idx;

endmodule

// File: rtl/beat_exp_checker.sv
module beat_exp_checker
    import beat_exp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_burst,
    input logic [ADDR_W-1:0] req_addr,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_last,
    input logic [LEN_W-1:0]  beat_idx
);

    logic [1:0] held_burst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      held_burst_q <= '0;
        else if (req_valid && req_ready) held_burst_q <= req_burst;
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !beat_valid); // R9

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> beat_valid && beat_idx == '0 && beat_addr == $past(req_addr)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_idx) && $stable(beat_last)); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last |=> beat_valid && beat_idx == $past(beat_idx) + LEN_W'(1)); // R10

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready); // R3

    AST_NO_IDLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> !beat_last); // R3

    AST_FIXED_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        held_burst_q == 2'd0 && beat_valid && beat_ready && !beat_last |=> beat_addr == $past(beat_addr)); // R6

endmodule

bind axi_beat_expander beat_exp_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_beat_exp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_burst  (req_burst),
    .req_addr   (req_addr),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_last  (beat_last),
    .beat_idx   (beat_idx)
);

// File: tb/axi_beat_expander_bench.sv
`timescale 1ns/1ps
module axi_beat_expander_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_burst = '0;
    logic [2:0]  req_size = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_prot = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [2:0]  beat_prot;
    logic        beat_last;
    logic [7:0]  beat_idx;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int k = 0;

    always #2 clk = ~clk;

    axi_beat_expander u_axi_beat_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_burst  (req_burst),
        .req_size   (req_size),
        .req_len    (req_len),
        .req_prot   (req_prot),
        .beat_valid (beat_valid),
        .beat_ready (beat_ready),
        .beat_addr  (beat_addr),
        .beat_prot  (beat_prot),
        .beat_last  (beat_last),
        .beat_idx   (beat_idx)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    function automatic logic [31:0] ref_addr(input logic [1:0] bu, input logic [2:0] sz,
                                             input logic [7:0] ln, input logic [31:0] st, input int i);
        logic [31:0] b, span, al, base;
        b    = 32'd1 << sz;
        span = b * (32'(ln) + 32'd1);
        al   = st & ~(b - 32'd1);
        if (i == 0)      return st;
        if (bu == 2'd0)  return st;
        if (bu == 2'd2) begin
            base = al & ~(span - 32'd1);
            return base + ((al - base + 32'(i) * b) % span);
        end
        return al + 32'(i) * b;
    endfunction

    function automatic string addr_tag(input logic [1:0] bu, input logic [2:0] sz, input logic [31:0] st, input int i);
        logic [31:0] b;
        b = 32'd1 << sz;
        if (bu == 2'd0) return "R6 fixed address";
        if (bu == 2'd2) return "R7 wrap address";
        if (bu == 2'd3) return "R12 reserved type as incr";
        if (i > 0 && (st & (b - 32'd1)) != 0) return "R8 unaligned start then aligned";
        return "R5 incr address";
    endfunction

    task automatic run_burst(input logic [1:0] bu, input logic [2:0] sz, input logic [7:0] ln, input logic [31:0] st);
        logic [31:0] exp_a;
        logic [31:0] prev_a;
        logic [2:0]  pr;
        bit          stalled;
        bit          rdy;
        int          i;
        pr = {bu[0], sz[1:0]};
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready while idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = st;
        req_burst = bu;
        req_size  = sz;
        req_len   = ln;
        req_prot  = pr;
        beat_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~st;
        req_len   = ~ln;
        req_prot  = ~pr;
        req_burst = ~bu;
        i = 0;
        stalled = 1'b0;
        prev_a = '0;
        while (i <= int'(ln)) begin
            exp_a = ref_addr(bu, sz, ln, st, i);
            chk(beat_valid === 1'b1, "R2 beat valid held", 32'(beat_valid), 32'd1);
            chk(beat_addr === exp_a, addr_tag(bu, sz, st, i), beat_addr, exp_a);
            chk(beat_last === (i == int'(ln)), "R3 last flag", 32'(beat_last), 32'(i == int'(ln)));
            chk(beat_idx === 8'(i), "R10 beat index", 32'(beat_idx), 32'(i));
            chk(beat_prot === pr, "R11 prot carried", 32'(beat_prot), 32'(pr));
            chk(req_ready === 1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
            if (stalled) chk(beat_addr === prev_a, "R4 hold under stall", beat_addr, prev_a);
            prev_a = beat_addr;
            rdy = (((k * 5) + 3) % 7) < 4;
            k++;
            beat_ready = rdy;
            @(negedge clk);
            if (rdy) begin
                i++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
            end
        end
        beat_ready = 1'b0;
        chk(beat_valid === 1'b0, "R3 no beat after final", 32'(beat_valid), 32'd0);
        chk(req_ready === 1'b1, "R9 ready back after final", 32'(req_ready), 32'd1);
    endtask

    initial begin
        logic [7:0]  lens [5];
        logic [31:0] starts [3];
        lens[0] = 8'd0; lens[1] = 8'd1; lens[2] = 8'd3; lens[3] = 8'd7; lens[4] = 8'd15;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        chk(beat_valid === 1'b0, "R1 valid low in reset", 32'(beat_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(beat_valid === 1'b0, "R1 valid low after reset", 32'(beat_valid), 32'd0);
        chk(beat_idx === 8'd0, "R1 index zero after reset", 32'(beat_idx), 32'd0);
        for (int bu = 0; bu < 4; bu++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int li = 0; li < 5; li++) begin
                    if (bu == 2 && li == 0) continue;
                    starts[0] = 32'h0000_0040;
                    starts[1] = 32'hFFFF_FFF0;
                    starts[2] = (bu == 2) ? 32'h0000_1238 : 32'h0000_123B;
                    for (int si = 0; si < 3; si++) begin
                        run_burst(2'(bu), 3'(sz), lens[li], starts[si]);
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule